// File: doc/BRIEF.md
# Serial Configuration Memory Emulator

This block stands in for a small serial configuration memory of 64 words of 16 bits. Software drives the serial pins by writing a control register: a shift clock bit, a select bit and a data-in bit. It samples the data-out bit by reading the same register back. Every change of the written clock bit counts as a shift-clock edge. No real clock is divided down. The block collects a 9-bit command made of a 3-bit opcode and a 6-bit word address. When the opcode is a read, it streams the addressed word out most significant bit first and runs on into the following words.

A second register gives a one-shot word lookup. Software writes a word address, and the read value carries the stored word together with a completion flag. Both paths read the same constant image. The image is built from parameters: a 48-bit station address in words 0 to 2, a fill pattern in the middle words, and a final checksum word that makes the 16-bit sum of the whole image equal a fixed target.

The serial decoder is a three-state machine:
- SER_COLLECT gathers command bits. It moves to SER_STREAM on the ninth bit when the opcode is a read (transition CMD_READ), and to SER_DISCARD on any other opcode (transition CMD_OTHER).
- From SER_STREAM and SER_DISCARD, a rising shift clock with select low returns the machine to SER_COLLECT (transition DESELECT). The same event in SER_COLLECT also clears the collected bits.

Top module: `eeprom_emu_top`

## Requirements
- R1: A control write whose shift-clock bit (bit 0) equals the retained shift-clock bit changes no serial state, so the data-out bit stays the same. A cycle with no control write leaves the control readback unchanged.
- R2: Control readback always shows bit 8 (present) and bit 7 (grant) set. Bit 3 is data-out. Only written bits 0 (clock), 1 (select), 2 (data-in), 5:4 (write enable) and 6 (request) are retained. All other bits read 0.
- R3: Each falling shift-clock edge advances the 10-bit output bit pointer by one, modulo 1024.
- R4: A rising shift-clock edge with select (bit 1) low clears the collected bits, the bit count, the output pointer and the read state. Data-out then reads 1.
- R5: A rising edge with select high shifts data-in into the least significant end of the command. The ninth such bit completes the command: bits 8:6 are the opcode and bits 5:0 are the word address, both sent most significant bit first.
- R6: Opcode 110 (binary) starts a read with the pointer at address*16-1. Right after the command, data-out is bit 0 of word address-1. After each following falling edge it is the next bit of word address, from bit 15 down to bit 0.
- R7: Any other opcode leaves data-out at 1 until the next deselect reset.
- R8: Streaming continues past the end of a word into the next word, and wraps from word 63 to word 0.
- R9: The word port reads 0 when its address field (written bits 15:8) is above 63.
- R10: Otherwise the word port reads the word in bits 31:16, written bits 15:2 in place, done (bit 1) as 1 and request (bit 0) as 0.
- R11: Word i (i = 0..2) is {station byte 2i+1, station byte 2i}, with byte 0 in station bits 7:0. Words 3..62 are FILL_BASE+i. Word 63 makes the 16-bit sum of all 64 words equal SUM_TARGET.
- R12: After reset, control readback is 0x188 (not reading, so data-out is 1) and the word port reads word 0 with done set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| ctl_rdata | output | 32 | Control register readback with data-out |
| wp_we | input | 1 | Word port write strobe |
| wp_wdata | input | 16 | Word port address and request write value |
| wp_rdata | output | 32 | Word port result |

## Verification
The bench builds the block with a station address of 0x665544332211, a fill base of 0x3C00 and the default sum target of 0xBABA. With these values every image word is distinct and the expected data can be computed independently. The default 6-bit address width puts word 63 within reach, so the bench can exercise the checksum word, the 63-to-0 wrap of a stream and out-of-range lookups at 64 and 200. A behavioural model of the pointer, command counter and read flag is compared against both readbacks on every clock.

// File: rtl/eeprom_emu_pkg.sv
package eeprom_emu_pkg;

    typedef logic [15:0] word_t;

    // control register bit positions
    localparam int CTL_SK   = 0;
    localparam int CTL_CS   = 1;
    localparam int CTL_DI   = 2;
    localparam int CTL_DO   = 3;
    localparam int CTL_PRES = 8;
    localparam int CTL_GNT  = 7;
    localparam logic [31:0] CTL_KEEP_MASK = 32'h0000_0077;

    localparam logic [2:0] OP_READ = 3'b110;

    // word port field positions
    localparam int WP_ADDR_LO = 8;
    localparam int WP_ADDR_W  = 8;
    localparam logic [15:0] WP_DONE_BIT = 16'h0002;
    localparam logic [15:0] WP_REQ_CLR  = 16'hFFFE;

    typedef enum logic [1:0] {
        SER_COLLECT = 2'd0,
        SER_STREAM  = 2'd1,
        SER_DISCARD = 2'd2
    } ser_state_t;

    function automatic word_t plain_word(int idx, logic [47:0] station, word_t fill_base);
        word_t w;
        if (idx < 3) begin
            w = {station[idx*16+8 +: 8], station[idx*16 +: 8]};
        end else begin
            w = fill_base + word_t'(idx);
        end
        return w;
    endfunction

    function automatic word_t check_word(int words, logic [47:0] station,
                                         word_t fill_base, word_t target);
        word_t acc;
        acc = '0;
        for (int i = 0; i < words - 1; i++) begin
            acc = acc + plain_word(i, station, fill_base);
        end
        return target - acc;
    endfunction

    function automatic word_t image_word(int idx, int words, logic [47:0] station,
                                         word_t fill_base, word_t target);
        word_t w;
        if (idx == words - 1) begin
            w = check_word(words, station, fill_base, target);
        end else begin
            w = plain_word(idx, station, fill_base);
        end
        return w;
    endfunction

endpackage

// File: rtl/eeprom_emu_image.sv
module eeprom_emu_image
    import eeprom_emu_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter logic [47:0] STATION    = 48'h0000_0000_0000,
    parameter logic [15:0] FILL_BASE  = 16'hFFFF,
    parameter logic [15:0] SUM_TARGET = 16'hBABA
) (
    input  logic [ADDR_W-1:0] ser_addr,
    output word_t             ser_word,
    input  logic [ADDR_W-1:0] port_addr,
    output word_t             port_word
);
    localparam int WORDS = 1 << ADDR_W;

    word_t image [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign image[k] = image_word(k, WORDS, STATION, FILL_BASE, SUM_TARGET);
    end

    assign ser_word  = image[ser_addr];
    assign port_word = image[port_addr];

endmodule

// File: rtl/eeprom_emu_serial.sv
module eeprom_emu_serial
    import eeprom_emu_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [31:0]         wdata,
    output logic [31:0]         keep_bits,
    output logic                reading,
    output logic [ADDR_W+3:0]   bit_ptr
);
    localparam int CMD_W = 3 + ADDR_W;
    localparam int PTR_W = ADDR_W + 4;
    localparam int CNT_W = $clog2(CMD_W + 1);

    ser_state_t         state_q, state_d;
    logic [31:0]        keep_q;
    logic [CMD_W-2:0]   shift_q;
    logic [CMD_W-1:0]   shift_next;
    logic [CNT_W-1:0]   cnt_q;
    logic [PTR_W-1:0]   ptr_q;
    logic               sk_rise, sk_fall, sel, deselect, shift_in, cmd_done;
    logic [2:0]         opcode;
    logic [ADDR_W-1:0]  cmd_addr;

    assign sk_rise    = we &  wdata[CTL_SK] & ~keep_q[CTL_SK];
    assign sk_fall    = we & ~wdata[CTL_SK] &  keep_q[CTL_SK];
    assign sel        = wdata[CTL_CS];
    assign deselect   = sk_rise & ~sel;
    assign shift_in   = sk_rise &  sel;
    assign shift_next = {shift_q, wdata[CTL_DI]};
    assign opcode     = shift_next[CMD_W-1 -: 3];
    assign cmd_addr   = shift_next[ADDR_W-1:0];
    assign cmd_done   = shift_in && (state_q == SER_COLLECT) &&
                        (cnt_q == CNT_W'(CMD_W - 1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_COLLECT: begin
                if (cmd_done) begin
                    state_d = (opcode == OP_READ) ? SER_STREAM : SER_DISCARD;
                end
            end
            SER_STREAM, SER_DISCARD: begin
                if (deselect) begin
                    state_d = SER_COLLECT;
                end
            end
            default: state_d = SER_COLLECT;
        endcase
        if (deselect) begin
            state_d = SER_COLLECT;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    // serial datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q  <= '0;
            shift_q <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
        end else if (we) begin
            keep_q <= wdata & CTL_KEEP_MASK;
            if (deselect) begin
                shift_q <= '0;
                cnt_q   <= '0;
                ptr_q   <= '0;
            end else if (shift_in) begin
                shift_q <= shift_next[CMD_W-2:0];
                if (state_q == SER_COLLECT) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                if (cmd_done) begin
                    ptr_q <= {cmd_addr, 4'b0000} - PTR_W'(1);
                end
            end else if (sk_fall) begin
                ptr_q <= ptr_q + PTR_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        keep_bits = keep_q;
        bit_ptr   = ptr_q;
        reading   = (state_q == SER_STREAM);
    end

endmodule

// File: rtl/eeprom_emu_wordport.sv
module eeprom_emu_wordport
    import eeprom_emu_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [15:0]       wdata,
    input  word_t             word_in,
    output logic [ADDR_W-1:0] word_addr,
    output logic [31:0]       rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [15:0]          held_q;
    logic [WP_ADDR_W-1:0] addr_field;
    logic                 in_range;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (we) begin
            held_q <= wdata;
        end
    end

    assign addr_field = held_q[WP_ADDR_LO +: WP_ADDR_W];
    assign in_range   = int'(addr_field) < WORDS;
    assign word_addr  = addr_field[ADDR_W-1:0];
    assign rdata      = in_range ? {word_in, (held_q | WP_DONE_BIT) & WP_REQ_CLR} : 32'h0;

endmodule

// File: rtl/eeprom_emu_top.sv
module eeprom_emu_top
    import eeprom_emu_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter logic [47:0] STATION    = 48'h0000_0000_0000,
    parameter logic [15:0] FILL_BASE  = 16'hFFFF,
    parameter logic [15:0] SUM_TARGET = 16'hBABA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic        wp_we,
    input  logic [15:0] wp_wdata,
    output logic [31:0] wp_rdata
);
    localparam int PTR_W = ADDR_W + 4;

    logic [31:0]       keep_bits;
    logic              reading;
    logic [PTR_W-1:0]  bit_ptr;
    word_t             ser_word, port_word;
    logic [ADDR_W-1:0] port_addr;
    logic              do_bit;

    eeprom_emu_serial #(.ADDR_W(ADDR_W)) i_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctl_we),
        .wdata     (ctl_wdata),
        .keep_bits (keep_bits),
        .reading   (reading),
        .bit_ptr   (bit_ptr)
    );

    eeprom_emu_image #(
        .ADDR_W     (ADDR_W),
        .STATION    (STATION),
        .FILL_BASE  (FILL_BASE),
        .SUM_TARGET (SUM_TARGET)
    ) i_image (
        .ser_addr  (bit_ptr[PTR_W-1:4]),
        .ser_word  (ser_word),
        .port_addr (port_addr),
        .port_word (port_word)
    );

    eeprom_emu_wordport #(.ADDR_W(ADDR_W)) i_wordport (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wp_we),
        .wdata     (wp_wdata),
        .word_in   (port_word),
        .word_addr (port_addr),
        .rdata     (wp_rdata)
    );

    // bit 15 of the word leaves first: index is inverted pointer low nibble
    assign do_bit = reading ? ser_word[~bit_ptr[3:0]] : 1'b1;

    always_comb begin
        ctl_rdata = keep_bits;
        ctl_rdata[CTL_PRES] = 1'b1;
        ctl_rdata[CTL_GNT]  = 1'b1;
        ctl_rdata[CTL_DO]   = do_bit;
    end

endmodule

// File: rtl/eeprom_emu_checker.sv
module eeprom_emu_checker
    import eeprom_emu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic [31:0] ctl_wdata,
    input logic [31:0] ctl_rdata,
    input logic [31:0] wp_rdata
);

    // R1
    sk_hold_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && (ctl_wdata[CTL_SK] == ctl_rdata[CTL_SK])) |=> $stable(ctl_rdata[CTL_DO]));

    // R1
    quiet_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_rdata));

    // R2
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_PRES] && ctl_rdata[CTL_GNT]);

    // R2
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ((ctl_rdata & CTL_KEEP_MASK) == ($past(ctl_wdata) & CTL_KEEP_MASK)));

    // R4
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[CTL_SK] && !ctl_rdata[CTL_SK] && !ctl_wdata[CTL_CS])
        |=> ctl_rdata[CTL_DO]);

    // R10
    wp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_rdata != 32'h0) |-> (wp_rdata[1:0] == 2'b10));

endmodule

bind eeprom_emu_top eeprom_emu_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .wp_rdata  (wp_rdata)
);

// File: tb/test_eeprom_emu_top.sv
`timescale 1ns/1ps
module test_eeprom_emu_top;

    localparam logic [47:0] ST   = 48'h6655_4433_2211;
    localparam logic [15:0] FILL = 16'h3C00;
    localparam logic [15:0] TGT  = 16'hBABA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        wp_we = 1'b0;
    logic [15:0] wp_wdata = '0;
    logic [31:0] wp_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    eeprom_emu_top #(.ADDR_W(6), .STATION(ST), .FILL_BASE(FILL), .SUM_TARGET(TGT)) i_eeprom_emu_top (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .wp_we(wp_we), .wp_wdata(wp_wdata), .wp_rdata(wp_rdata)
    );

    // expected image, built from R11
    logic [15:0] bimg [64];
    initial begin
        logic [15:0] s;
        s = 16'h0;
        bimg[0] = 16'h2211; bimg[1] = 16'h4433; bimg[2] = 16'h6655;
        for (int i = 3; i < 63; i++) bimg[i] = FILL + 16'(i);
        for (int i = 0; i < 63; i++) s = s + bimg[i];
        bimg[63] = TGT - s;
    end

    // behavioural reference model
    int          m_ptr, m_cnt;
    bit          m_reading;
    logic [31:0] m_shift, m_keep;
    logic [15:0] m_wp;

    task automatic model_reset();
        m_ptr = 0; m_cnt = 0; m_reading = 0; m_shift = 0;
    endtask

    task automatic model_ctl(input logic [31:0] v);
        bit old_sk;
        old_sk = m_keep[0];
        m_keep = v & 32'h77;
        if (v[0] != old_sk) begin
            if (!v[0]) begin
                m_ptr = (m_ptr + 1) % 1024;
            end else if (!v[1]) begin
                model_reset();
            end else begin
                m_shift = (m_shift << 1) | {31'b0, v[2]};
                m_cnt++;
                if (m_cnt == 9 && !m_reading) begin
                    m_ptr = (int'(m_shift & 32'h3F) * 16 + 1023) % 1024;
                    m_reading = (((m_shift >> 6) & 32'h7) == 32'h6);
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
            m_keep = 0;
            m_wp = 0;
        end else begin
            if (ctl_we) model_ctl(ctl_wdata);
            if (wp_we) m_wp = wp_wdata;
        end
    end

    function automatic logic exp_do();
        if (!m_reading) return 1'b1;
        return bimg[(m_ptr >> 4) & 63][15 - (m_ptr & 15)];
    endfunction

    function automatic logic [31:0] exp_ctl();
        return m_keep | 32'h180 | {28'b0, exp_do(), 3'b0};
    endfunction

    function automatic logic [31:0] exp_wp();
        int a;
        a = int'(m_wp[15:8]);
        if (a > 63) return 32'h0;
        return {bimg[a], (m_wp | 16'h0002) & 16'hFFFE};
    endfunction

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (ctl_rdata !== exp_ctl()) begin
                errors++;
                $display("FAIL R2 model ctl actual=%h expected=%h", ctl_rdata, exp_ctl());
            end
            checks++;
            if (wp_rdata !== exp_wp()) begin
                errors++;
                $display("FAIL R10 model wp actual=%h expected=%h", wp_rdata, exp_wp());
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [31:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic ser(input bit cs, input bit di, input bit sk);
        ctl_write({29'b0, di, cs, sk});
    endtask

    task automatic wp_write(input logic [15:0] v);
        @(negedge clk);
        wp_we = 1'b1; wp_wdata = v;
        @(negedge clk);
        wp_we = 1'b0;
    endtask

    task automatic deselect();
        ser(0, 0, 0);
        ser(0, 0, 1);
        ser(0, 0, 0);
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [5:0] a);
        logic [8:0] c;
        c = {op, a};
        ser(1, 0, 0);
        for (int i = 8; i >= 0; i--) begin
            ser(1, c[i], 0);
            ser(1, c[i], 1);
        end
    endtask

    initial begin
        logic [15:0] sum;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset ctl", ctl_rdata, 32'h188);
        chk("R12 reset wp", wp_rdata, {bimg[0], 16'h0002});

        // R11 image contents through the word port
        for (int i = 0; i < 3; i++) begin
            wp_write(16'(i) << 8);
            chk("R11 station word", {16'h0, wp_rdata[31:16]}, {16'h0, bimg[i]});
        end
        wp_write(16'h0500);
        chk("R11 fill word", {16'h0, wp_rdata[31:16]}, {16'h0, FILL + 16'd5});
        sum = 16'h0;
        for (int i = 0; i < 64; i++) begin
            wp_write(16'(i) << 8);
            sum = sum + wp_rdata[31:16];
        end
        chk("R11 image sum", {16'h0, sum}, {16'h0, TGT});

        // R9 out of range, R10 format
        wp_write(16'h4001);
        chk("R9 addr 64", wp_rdata, 32'h0);
        wp_write(16'hC801);
        chk("R9 addr 200", wp_rdata, 32'h0);
        wp_write(16'h0A05);
        chk("R10 format", wp_rdata, {bimg[10], 16'h0A06});

        // R2 retained bits
        ctl_write(32'hFFFF_FFF8);
        chk("R2 retained", ctl_rdata & ~32'h8, 32'h1F0);
        ctl_write(32'h0);

        // R5 R6 R3 read word 42
        deselect();
        send_cmd(3'b110, 6'd42);
        chk("R6 pre bit", {31'b0, ctl_rdata[3]}, {31'b0, bimg[41][0]});
        for (int k = 0; k < 16; k++) begin
            ser(1, 0, 0);
            chk("R3 stream bit", {31'b0, ctl_rdata[3]}, {31'b0, bimg[42][15-k]});
            ser(1, 0, 1);
        end
        // R1 write without SK change: select and data-in move, data-out holds
        begin
            logic d0;
            d0 = ctl_rdata[3];
            ser(0, 1, 1);
            chk("R1 no edge", {31'b0, ctl_rdata[3]}, {31'b0, d0});
            ser(1, 0, 1);
            chk("R1 no edge again", {31'b0, ctl_rdata[3]}, {31'b0, d0});
        end
        ser(1, 0, 0);
        chk("R5 next word", {31'b0, ctl_rdata[3]}, {31'b0, bimg[43][15]});

        // R4 deselect reset
        ser(0, 0, 1);
        chk("R4 deselect", {31'b0, ctl_rdata[3]}, 32'h1);
        ser(0, 0, 0);
        chk("R4 idle after fall", {31'b0, ctl_rdata[3]}, 32'h1);

        // R8 wrap from word 63 to word 0
        send_cmd(3'b110, 6'd63);
        for (int k = 0; k < 32; k++) begin
            ser(1, 0, 0);
            chk("R8 wrap stream", {31'b0, ctl_rdata[3]},
                {31'b0, (k < 16) ? bimg[63][15-k] : bimg[0][31-k]});
            ser(1, 0, 1);
        end

        // R7 non-read opcode
        deselect();
        send_cmd(3'b101, 6'd3);
        for (int k = 0; k < 20; k++) begin
            ser(1, 1, 0);
            chk("R7 other opcode", {31'b0, ctl_rdata[3]}, 32'h1);
            ser(1, 0, 1);
        end
        deselect();
        send_cmd(3'b110, 6'd1);
        ser(1, 0, 0);
        chk("R7 read after reset", {31'b0, ctl_rdata[3]}, {31'b0, bimg[1][15]});

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule